// File: doc/BRIEF.md
# Disk Track Operation Sequencer

This block steps one track read or write operation through its phases once the control cycle has been accepted. A start strobe leaves the idle state. The prepare phase waits for the preparation-complete input and then raises the monitor flags. The block then arms on the early index pulse. That pulse fires an amplifier-squelch interval, and an internal counter times it. After the squelch has expired, the next late index pulse moves the block to the long-gap wait. The trailing edge of the long gap opens address verification.

An external comparator reports the result of address verification. A failed compare ends the operation at once with unusual status. A passing compare enters data transfer. During transfer, a write operation raises the write gate at the next B1 bit-time strobe. Transfer ends with normal status in one of two ways: at the end of an area once the host has asked to stop, or at end of track. A machine-idle input aborts the operation at any point and clears the write gate.

Top module: `trk_op_seq`

## Requirements
- R1: After reset, `phase` is 0 and every other output is 0.
- R2: `start` in phase 0 moves to phase 1. `prep_ok` in phase 1 moves to phase 2 and sets all three bits of `prep_flags`. The flags clear on the return to phase 0. `start` outside phase 0 has no effect.
- R3: `early_idx` in phase 2 moves to phase 3 and raises `squelch` for exactly SQ_CYCLES cycles, where SQ_CYCLES = CLK_MHZ * SQ_US. A further `early_idx` during the squelch does not retrigger or extend it.
- R4: `late_idx` during the squelch is ignored. When the squelch expires the block enters phase 4, and the next `late_idx` moves it to phase 5.
- R5: `gap_trail` in phase 5 moves to phase 6 and raises `rd_gate`. `gap_trail` in phase 4 is ignored.
- R6: `cmp_valid` with `cmp_pass` low in phase 6 returns to phase 0 and gives a one-cycle `done_unusual` pulse.
- R7: `cmp_valid` with `cmp_pass` high in phase 6 moves to phase 7. In a write operation (`wr_op` high at `start`), `wr_gate` rises at the first `b1_time` in phase 7. In a read operation it stays low.
- R8: A `host_stop` seen during the operation makes the next `area_end` in phase 7 end the operation with a one-cycle `done_normal` pulse. Without a stop, `area_end` has no effect.
- R9: `end_track` in phase 7 ends the operation with `done_normal`, whether or not a stop was requested.
- R10: `idle_clr` returns the block to phase 0 on the next edge and clears `wr_gate`, `rd_gate`, `squelch` and `prep_flags`, with no done pulse.
- R11: Phase codes are: 0 idle, 1 prepare, 2 armed, 3 squelch, 4 index hold wait, 5 gap wait, 6 verify, 7 transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_clr | input | 1 | Machine-idle abort |
| start | input | 1 | Read or write trigger |
| wr_op | input | 1 | 1 selects write, sampled at start |
| prep_ok | input | 1 | Prepare phase completed |
| early_idx | input | 1 | Early index pulse |
| late_idx | input | 1 | Late index pulse |
| gap_trail | input | 1 | Long gap trailing edge |
| cmp_valid | input | 1 | Address compare result valid |
| cmp_pass | input | 1 | Address compare matched |
| b1_time | input | 1 | B1 bit-time strobe |
| area_end | input | 1 | End of current area |
| end_track | input | 1 | End of track |
| host_stop | input | 1 | Host stop request |
| phase | output | 3 | Current phase code |
| prep_flags | output | 3 | Select, ready-monitor, read-monitor flags |
| squelch | output | 1 | Amplifier squelch pulse |
| rd_gate | output | 1 | Read gate (verify and transfer) |
| wr_gate | output | 1 | Write gate |
| done_normal | output | 1 | Normal end pulse |
| done_unusual | output | 1 | Unusual end pulse |

## Verification
The assertions check on every cycle that the machine-idle abort always lands in idle with the write gate down, and that a failed compare always produces the unusual end. They also check that the write gate only rises on a B1 strobe in a write operation, that the read gate only opens after a gap edge, that the squelch is never re-fired while it runs, and that the two end pulses never coincide. Only the bench scenarios can show the exact squelch length and the index pairing that ignores early late pulses. The same holds for the difference between an area end with a stop and one without, and for the absence of a write gate in read operations.

// File: rtl/trk_seq_pkg.sv
package trk_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_PREP = 3'd1, PH_ARM  = 3'd2, PH_SQL  = 3'd3,
    PH_HOLD = 3'd4, PH_GAP  = 3'd5, PH_VER  = 3'd6, PH_XFER = 3'd7
  } phase_t;

  // squelch length in clock cycles
  function automatic int unsigned sq_len(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned cnt_bits(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/trk_sq_timer.sv
module trk_sq_timer #(
  parameter int unsigned LEN = 70000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fire,
  output logic busy,
  output logic tmo
);
  localparam int unsigned CW = trk_seq_pkg::cnt_bits(LEN);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   cnt <= '0;
    else if (fire)       cnt <= CW'(LEN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign tmo  = (cnt == CW'(1));

  // R3: a fire always starts the interval
  p_fire_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> busy);
  // R3: the interval only ends through the timeout cycle or a clear
  p_end_via_tmo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(tmo) || $past(clr)));
endmodule

// File: rtl/trk_xfer_ctl.sv
module trk_xfer_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic in_xfer,
  input  logic wr_q,
  input  logic b1,
  input  logic stop_in,
  output logic wr_gate,
  output logic stop_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_gate <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (in_xfer && wr_q && b1) wr_gate <= 1'b1;
      if (active && stop_in)     stop_q  <= 1'b1;
    end
  end

  // R7: write gate rises only on a B1 strobe of a write operation
  p_wgate_b1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_gate) |-> ($past(b1) && $past(wr_q) && $past(in_xfer)));
endmodule

// File: rtl/trk_op_seq.sv
module trk_op_seq #(
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned SQ_US   = 350
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_clr,
  input  logic       start,
  input  logic       wr_op,
  input  logic       prep_ok,
  input  logic       early_idx,
  input  logic       late_idx,
  input  logic       gap_trail,
  input  logic       cmp_valid,
  input  logic       cmp_pass,
  input  logic       b1_time,
  input  logic       area_end,
  input  logic       end_track,
  input  logic       host_stop,
  output logic [2:0] phase,
  output logic [2:0] prep_flags,
  output logic       squelch,
  output logic       rd_gate,
  output logic       wr_gate,
  output logic       done_normal,
  output logic       done_unusual
);
  import trk_seq_pkg::*;
  localparam int unsigned SQ_CYCLES = sq_len(CLK_MHZ, SQ_US);

  phase_t state, state_nx;
  logic   wr_q, first_idx, mon_q;
  logic   sq_fire, sq_busy, sq_tmo;
  logic   end_ok, end_bad, go_idle, stop_q;

  // named internal events
  assign sq_fire = (state == PH_ARM) && early_idx && !idle_clr;
  assign end_bad = (state == PH_VER) && cmp_valid && !cmp_pass;
  assign end_ok  = (state == PH_XFER) &&
                   (end_track || (area_end && (stop_q || host_stop)));
  assign go_idle = idle_clr || end_ok || end_bad;

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE: if (start)                  state_nx = PH_PREP;
      PH_PREP: if (prep_ok)                state_nx = PH_ARM;
      PH_ARM:  if (early_idx)              state_nx = PH_SQL;
      PH_SQL:  if (sq_tmo)                 state_nx = PH_HOLD;
      PH_HOLD: if (late_idx && first_idx)  state_nx = PH_GAP;
      PH_GAP:  if (gap_trail)              state_nx = PH_VER;
      PH_VER:  if (cmp_valid)              state_nx = cmp_pass ? PH_XFER : PH_IDLE;
      PH_XFER: if (end_ok)                 state_nx = PH_IDLE;
      default:                             state_nx = PH_IDLE;
    endcase
    if (idle_clr) state_nx = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= PH_IDLE;
      wr_q         <= 1'b0;
      first_idx    <= 1'b0;
      mon_q        <= 1'b0;
      done_normal  <= 1'b0;
      done_unusual <= 1'b0;
    end else begin
      state        <= state_nx;
      done_normal  <= end_ok  && !idle_clr;
      done_unusual <= end_bad && !idle_clr;
      if (go_idle) begin
        mon_q     <= 1'b0;
        first_idx <= 1'b0;
      end else begin
        if (state == PH_IDLE && start)               wr_q      <= wr_op;
        if (state == PH_PREP && prep_ok)             mon_q     <= 1'b1;
        if (sq_fire)                                 first_idx <= 1'b1;
        if (state == PH_HOLD && late_idx && first_idx) first_idx <= 1'b0;
      end
    end
  end

  trk_sq_timer #(.LEN(SQ_CYCLES)) u_sq (
    .clk(clk), .rst_n(rst_n), .clr(idle_clr), .fire(sq_fire),
    .busy(sq_busy), .tmo(sq_tmo)
  );

  trk_xfer_ctl u_xf (
    .clk(clk), .rst_n(rst_n), .clr(go_idle),
    .active(state != PH_IDLE), .in_xfer(state == PH_XFER),
    .wr_q(wr_q), .b1(b1_time), .stop_in(host_stop),
    .wr_gate(wr_gate), .stop_q(stop_q)
  );

  assign phase      = state;
  assign prep_flags = {3{mon_q}};
  assign squelch    = sq_busy;
  assign rd_gate    = (state == PH_VER) || (state == PH_XFER);

  // R10: machine idle always lands in idle with the write gate down
  p_idle_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_clr |=> (phase == 3'd0 && !wr_gate && !done_normal && !done_unusual));
  // R6: failed compare gives the unusual end
  p_fail_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_bad && !idle_clr) |=> (done_unusual && phase == 3'd0));
  // R5: read gate opens only after a gap edge
  p_rdgate_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_gate) |-> $past(gap_trail));
  // R3: the squelch is never fired while it runs
  p_no_refire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sq_busy |-> !sq_fire);
  // R8: the two end pulses never coincide
  p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_normal && done_unusual));
endmodule

// File: tb/trk_op_seq_test.sv
`timescale 1ns/1ps
module trk_op_seq_test;
  localparam int MHZ = 4, US = 3;
  localparam int EXP_SQ = MHZ * US;   // 12 cycles
  // stimulus bit positions
  localparam int B_START = 0, B_PREP = 1, B_EARLY = 2, B_LATE = 3, B_GAP = 4,
                 B_CMPV = 5, B_PASS = 6, B_B1 = 7, B_AEND = 8, B_ETRK = 9,
                 B_STOP = 10, B_CLR = 11;

  logic clk = 0, rst_n = 0, wr_op = 0;
  logic [11:0] stim = '0;
  logic [2:0] phase, prep_flags;
  logic squelch, rd_gate, wr_gate, done_normal, done_unusual;
  int checks = 0, errors = 0;
  bit finished = 0;
  byte exp_kind[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  trk_op_seq #(.CLK_MHZ(MHZ), .SQ_US(US)) uut (
    .clk(clk), .rst_n(rst_n), .idle_clr(stim[B_CLR]), .start(stim[B_START]),
    .wr_op(wr_op), .prep_ok(stim[B_PREP]), .early_idx(stim[B_EARLY]),
    .late_idx(stim[B_LATE]), .gap_trail(stim[B_GAP]), .cmp_valid(stim[B_CMPV]),
    .cmp_pass(stim[B_PASS]), .b1_time(stim[B_B1]), .area_end(stim[B_AEND]),
    .end_track(stim[B_ETRK]), .host_stop(stim[B_STOP]),
    .phase(phase), .prep_flags(prep_flags), .squelch(squelch), .rd_gate(rd_gate),
    .wr_gate(wr_gate), .done_normal(done_normal), .done_unusual(done_unusual)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int bits);
    stim = 12'(bits);
    @(negedge clk);
    stim = '0;
  endtask

  task automatic expect_end(input byte k, input string tag);
    exp_kind.push_back(k);
    exp_tag.push_back(tag);
  endtask

  // monitor: pops expected end events as the design produces them
  always @(negedge clk) if (rst_n && (done_normal || done_unusual)) begin
    checks++;
    if (exp_kind.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected end actual=%0d expected=0",
               {done_normal, done_unusual});
    end else begin
      automatic byte k = exp_kind.pop_front();
      automatic string t = exp_tag.pop_front();
      automatic byte a = done_normal ? "N" : "U";
      if (a != k || (done_normal && done_unusual)) begin
        errors++;
        $display("FAIL %s end kind actual=%c expected=%c", t, a, k);
      end
    end
  end

  task automatic go_xfer(input logic wr, input bit verbose);
    wr_op = wr;
    cyc(1 << B_START);
    if (verbose) chk("R2 phase after start", phase, 1);
    cyc(1 << B_PREP);
    if (verbose) begin
      chk("R2 phase after prep", phase, 2);
      chk("R2 prep flags", prep_flags, 7);
    end
    cyc(1 << B_EARLY);
    if (verbose) chk("R3 squelch on", squelch, 1);
    for (int i = 0; i < 200 && squelch; i++) @(negedge clk);
    cyc(1 << B_LATE);
    cyc(1 << B_GAP);
    cyc((1 << B_CMPV) | (1 << B_PASS));
    if (verbose) chk("R7 phase transfer", phase, 7);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 phase", phase, 0);
    chk("R1 outputs", {prep_flags, squelch, rd_gate, wr_gate, done_normal, done_unusual}, 0);

    // scenario A: write op, full step-through with index corner cases
    wr_op = 1;
    cyc(1 << B_START);
    chk("R2 phase after start", phase, 1);
    cyc(1 << B_START);
    chk("R2 start ignored in prepare", phase, 1);
    cyc(1 << B_PREP);
    chk("R11 phase armed", phase, 2);
    chk("R2 prep flags set", prep_flags, 7);
    cyc(1 << B_EARLY);
    chk("R3 phase squelch", phase, 3);
    begin
      int n = 0;
      do begin
        if (n == 3) stim = (1 << B_LATE) | (1 << B_EARLY);
        @(negedge clk);
        stim = '0;
        n++;
      end while (squelch && n < 200);
      chk("R3 squelch length", n, EXP_SQ);
    end
    chk("R4 late during squelch ignored", phase, 4);
    cyc(1 << B_GAP);
    chk("R5 gap in hold ignored phase", phase, 4);
    chk("R5 gap in hold ignored rd_gate", rd_gate, 0);
    cyc(1 << B_LATE);
    chk("R4 late after squelch", phase, 5);
    cyc(1 << B_GAP);
    chk("R5 phase verify", phase, 6);
    chk("R5 rd_gate open", rd_gate, 1);
    cyc((1 << B_CMPV) | (1 << B_PASS));
    chk("R7 phase transfer", phase, 7);
    chk("R7 wr_gate before B1", wr_gate, 0);
    cyc(1 << B_B1);
    chk("R7 wr_gate after B1", wr_gate, 1);
    cyc(1 << B_AEND);
    chk("R8 area end without stop", phase, 7);
    cyc(1 << B_STOP);
    chk("R8 stop alone does not end", phase, 7);
    expect_end("N", "R8");
    cyc(1 << B_AEND);
    chk("R8 back to idle", phase, 0);
    chk("R8 gates and flags clear", {wr_gate, rd_gate, prep_flags}, 0);
    @(negedge clk);

    // scenario B: read op, B1 gives no write gate, end of track ends
    go_xfer(1'b0, 1'b1);
    cyc(1 << B_B1);
    chk("R7 read op no wr_gate", wr_gate, 0);
    expect_end("N", "R9");
    cyc(1 << B_ETRK);
    chk("R9 idle after end of track", phase, 0);
    @(negedge clk);

    // scenario C: write op, stop early, end of track still normal end
    go_xfer(1'b1, 1'b0);
    cyc(1 << B_STOP);
    expect_end("N", "R9");
    cyc(1 << B_ETRK);
    chk("R9 idle after stop+end of track", phase, 0);
    @(negedge clk);

    // scenario D: compare fail
    wr_op = 1;
    cyc(1 << B_START); cyc(1 << B_PREP); cyc(1 << B_EARLY);
    for (int i = 0; i < 200 && squelch; i++) @(negedge clk);
    cyc(1 << B_LATE); cyc(1 << B_GAP);
    expect_end("U", "R6");
    cyc(1 << B_CMPV);
    chk("R6 idle after fail", phase, 0);
    chk("R6 rd_gate closed", rd_gate, 0);
    @(negedge clk);

    // scenario E: machine idle during transfer with write gate up
    go_xfer(1'b1, 1'b0);
    cyc(1 << B_B1);
    chk("R10 wr_gate up before abort", wr_gate, 1);
    cyc(1 << B_CLR);
    chk("R10 idle after abort", phase, 0);
    chk("R10 gates cleared", {wr_gate, rd_gate, prep_flags}, 0);
    @(negedge clk);

    // scenario F: machine idle during squelch
    cyc(1 << B_START); cyc(1 << B_PREP); cyc(1 << B_EARLY);
    @(negedge clk);
    cyc(1 << B_CLR);
    chk("R10 squelch cleared", squelch, 0);
    chk("R10 idle from squelch", phase, 0);
    repeat (3) @(negedge clk);

    chk("R8 all expected ends seen", exp_kind.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule